// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block sits beside a two-port shared memory and gives each port a doorbell. It watches the address, select, write and output-enable lines of both ports. Each port owns one reserved word at the top of the address space, and that word is its inbox. When the opposite port writes that word, the owner's interrupt line goes active. When the owner later reads its inbox, the interrupt is withdrawn. The message itself lives in the shared memory. This block only tracks whether a message is pending.

All strobes are active low. A port performs a write in a cycle when its select and write lines are both low. It performs a read when select is low, write is high and output enable is low. The flags are registered, so an interrupt changes on the clock edge that samples the qualifying access.

Top module: `mbx_irq`

## Requirements
- R1: While reset is asserted (rstN low), and at its release, both leftIrqN and rightIrqN are high (inactive).
- R2: A left-port write (leftSelN=0, leftWrN=0) to the right inbox, address 2^ADDR_W-2 (0x3FE for ADDR_W=10), drives rightIrqN low from the next rising clock edge.
- R3: A right-port write (rightSelN=0, rightWrN=0) to the left inbox, address 2^ADDR_W-1 (0x3FF for ADDR_W=10), drives leftIrqN low from the next rising clock edge.
- R4: A left-port read (leftSelN=0, leftWrN=1, leftOeN=0) of the left inbox 0x3FF returns leftIrqN high at the next rising edge, unless R3 applies in the same cycle.
- R5: A right-port read (rightSelN=0, rightWrN=1, rightOeN=0) of the right inbox 0x3FE returns rightIrqN high at the next rising edge, unless R2 applies in the same cycle.
- R6: When a set and a clear of the same flag fall in the same cycle, the set wins and the interrupt is low after the edge.
- R7: Any other activity leaves both flags unchanged. This includes a port writing its own inbox, reads with output enable high, deselected accesses and all other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| leftAddr | input | ADDR_W | Left port address |
| leftSelN | input | 1 | Left port select, active low |
| leftWrN | input | 1 | Left port write strobe, low = write |
| leftOeN | input | 1 | Left port output enable, active low |
| rightAddr | input | ADDR_W | Right port address |
| rightSelN | input | 1 | Right port select, active low |
| rightWrN | input | 1 | Right port write strobe, low = write |
| rightOeN | input | 1 | Right port output enable, active low |
| leftIrqN | output | 1 | Left port interrupt, active low |
| rightIrqN | output | 1 | Right port interrupt, active low |

## Verification
The assertions assume that every input is a clean synchronous level, already captured in the clock domain, so that each cycle holds at most one access per port. They also assume no input carries X after reset. The stimulus respects this by changing all inputs only on the falling edge. It draws addresses from a mix that hits both inboxes often, and it also produces random address, select, write and output-enable combinations. This mix reaches simultaneous set and clear, own-inbox writes and reads with output enable high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NPORT = 2;
  localparam int PL = 0;
  localparam int PR = 1;

  typedef struct packed {
    logic [NPORT-1:0] raise;
    logic [NPORT-1:0] drop;
  } mbx_strobe_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [NPORT-1:0][ADDR_W-1:0] addr,
  input  logic [NPORT-1:0]             selN,
  input  logic [NPORT-1:0]             wrN,
  input  logic [NPORT-1:0]             oeN,
  output mbx_strobe_t                  strb
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [NPORT-1:0] isWrite;
  logic [NPORT-1:0] isRead;
  logic [NPORT-1:0] raiseV;
  logic [NPORT-1:0] dropV;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int OTHER = NPORT - 1 - p;
    localparam logic [ADDR_W-1:0] BOX = TOP_ADDR - ADDR_W'(p);
    assign isWrite[p] = !selN[p] && !wrN[p];
    assign isRead[p]  = !selN[p] && wrN[p] && !oeN[p];
    // the inbox of port p is written by the other port, read by p itself
    assign raiseV[p]  = isWrite[OTHER] && (addr[OTHER] == BOX);
    assign dropV[p]   = isRead[p] && (addr[p] == BOX);
  end

  assign strb = '{raise: raiseV, drop: dropV};
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mbx_strobe_t      strb,
  output logic [NPORT-1:0] irqN
);
  for (genvar p = 0; p < NPORT; p++) begin : g_flag
    logic pend;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 pend <= 1'b0;
      else if (strb.raise[p])    pend <= 1'b1;  // set has priority
      else if (strb.drop[p])     pend <= 1'b0;
    end
    assign irqN[p] = ~pend;
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftSelN,
  input  logic              leftWrN,
  input  logic              leftOeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightSelN,
  input  logic              rightWrN,
  input  logic              rightOeN,
  output logic              leftIrqN,
  output logic              rightIrqN
);
  logic [NPORT-1:0][ADDR_W-1:0] addrV;
  logic [NPORT-1:0]             selV, wrV, oeV, irqV;
  mbx_strobe_t                  strb;

  assign addrV[PL] = leftAddr;
  assign addrV[PR] = rightAddr;
  assign selV      = {rightSelN, leftSelN};
  assign wrV       = {rightWrN, leftWrN};
  assign oeV       = {rightOeN, leftOeN};

  mbx_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addrV),
    .selN (selV),
    .wrN  (wrV),
    .oeN  (oeV),
    .strb (strb)
  );

  mbx_flags u_flags (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .irqN (irqV)
  );

  assign leftIrqN  = irqV[PL];
  assign rightIrqN = irqV[PR];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftSelN,
  input logic              leftWrN,
  input logic              leftOeN,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightSelN,
  input logic              rightWrN,
  input logic              rightOeN,
  input logic              leftIrqN,
  input logic              rightIrqN
);
  localparam logic [ADDR_W-1:0] LBOX = '1;
  localparam logic [ADDR_W-1:0] RBOX = LBOX - 1'b1;

  logic setL, setR, clrL, clrR;
  assign setL = !rightSelN && !rightWrN && rightAddr == LBOX;
  assign setR = !leftSelN && !leftWrN && leftAddr == RBOX;
  assign clrL = !leftSelN && leftWrN && !leftOeN && leftAddr == LBOX;
  assign clrR = !rightSelN && rightWrN && !rightOeN && rightAddr == RBOX;

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (leftIrqN && rightIrqN));
  a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rstN)
    setR |=> !rightIrqN);
  a_r3_right_sets_left: assert property (@(posedge clk) disable iff (!rstN)
    setL |=> !leftIrqN);
  a_r4_left_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrL && !setL) |=> leftIrqN);
  a_r5_right_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrR && !setR) |=> rightIrqN);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setL && clrL) |=> !leftIrqN);
  a_r7_left_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!setL && !clrL) |=> $stable(leftIrqN));
  a_r7_right_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!setR && !clrR) |=> $stable(rightIrqN));
endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbx_irq.sv
`timescale 1ns/1ps
module sim_mbx_irq;
  localparam int AW = 10;
  localparam logic [AW-1:0] LBOX = 10'h3FF;
  localparam logic [AW-1:0] RBOX = 10'h3FE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] lA = '0, rA = '0;
  logic lS = 1, lW = 1, lO = 1, rS = 1, rW = 1, rO = 1;
  logic leftIrqN, rightIrqN;
  logic expL = 1'b0, expR = 1'b0;  // pending (active) in model
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN),
    .leftAddr(lA), .leftSelN(lS), .leftWrN(lW), .leftOeN(lO),
    .rightAddr(rA), .rightSelN(rS), .rightWrN(rW), .rightOeN(rO),
    .leftIrqN(leftIrqN), .rightIrqN(rightIrqN)
  );

  function automatic logic nextFlag(logic cur, logic set, logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic string tagFor(logic set, logic clr, string setTag, string clrTag);
    if (set && clr) return "R6";
    if (set) return setTag;
    if (clr) return clrTag;
    return "R7";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [AW-1:0] la, logic ls, logic lw, logic lo,
                      logic [AW-1:0] ra, logic rs, logic rw, logic ro);
    logic sL, sR, cL, cR;
    @(negedge clk);
    lA = la; lS = ls; lW = lw; lO = lo;
    rA = ra; rS = rs; rW = rw; rO = ro;
    sL = !rs && !rw && ra == LBOX;
    sR = !ls && !lw && la == RBOX;
    cL = !ls && lw && !lo && la == LBOX;
    cR = !rs && rw && !ro && ra == RBOX;
    @(posedge clk);
    expL = nextFlag(expL, sL, cL);
    expR = nextFlag(expR, sR, cR);
    #1;
    check({tagFor(sL, cL, "R3", "R4"), " left"}, leftIrqN, ~expL);
    check({tagFor(sR, cR, "R2", "R5"), " right"}, rightIrqN, ~expR);
  endtask

  function automatic logic [AW-1:0] pickAddr();
    int k = $urandom_range(0, 3);
    if (k == 0) return LBOX;
    if (k == 1) return RBOX;
    return AW'($urandom);
  endfunction

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 left in reset", leftIrqN, 1'b1);
    check("R1 right in reset", rightIrqN, 1'b1);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 left after release", leftIrqN, 1'b1);
    check("R1 right after release", rightIrqN, 1'b1);

    // R7: own inbox writes do nothing
    step(LBOX, 0, 0, 1, RBOX, 0, 0, 1);
    // R2 / R3: cross writes set
    step(RBOX, 0, 0, 1, LBOX, 0, 0, 1);
    // R7: read with OE high, deselected read, hold
    step(LBOX, 0, 1, 1, RBOX, 1, 1, 0);
    // R4 / R5: reads clear
    step(LBOX, 0, 1, 0, RBOX, 0, 1, 0);
    // R6: right sets left while left reads left
    step(LBOX, 0, 1, 0, LBOX, 0, 0, 1);
    // R6: left sets right while right reads right
    step(RBOX, 0, 0, 1, RBOX, 0, 1, 0);
    // R7: other addresses
    step(10'h001, 0, 0, 0, 10'h3FD, 0, 0, 0);
    step(LBOX, 0, 1, 0, RBOX, 0, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      step(pickAddr(), 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
           pickAddr(), 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom));
    end

    // R1: reset mid-run returns both flags to idle
    step(RBOX, 0, 0, 1, LBOX, 0, 0, 1);
    @(negedge clk) rstN = 1'b0;
    #1;
    check("R1 left async reset", leftIrqN, 1'b1);
    check("R1 right async reset", rightIrqN, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule